// File: doc/BRIEF.md
# Serial Audio Transmitter with Auxiliary Byte Insertion

This block turns one stereo sample pair per frame into a serial bit stream, most significant bit first, clocked by an external bit clock and framed by an external frame clock. It offers four framings, selected at run time: left-justified, I2S (first bit one bit clock late), right-justified and a multi-slot TDM framing in which a one-bit sync pulse starts the frame. Each channel occupies a 32-bit subframe. When insertion is enabled, an 8-bit auxiliary byte per channel is packed into the subframe bits that the audio word does not use. These are the low byte for the left-justified, I2S and TDM framings and the high byte for right-justified framing.

A word-length control shortens the audio word to 16..24 bits and zeroes the discarded low-order bits. A bypass control cancels that shortening, so every one of the 24 sample bits leaves untouched, which lets non-audio payloads pass bit-exact. Both samples, both auxiliary bytes and the layout controls are captured at the start of each frame, so later changes to them cannot corrupt a frame that is already being sent. While insertion is enabled, the block watches the length of each subframe and raises a one-cycle error flag when that length is not 32 bit clocks.

Top module: `aux_audio_tx`

## Requirements
- R1: All state changes on the falling edge of `bclk`, and `fclk` is captured on that edge. `fmt_sel` encodes 0 = left-justified, 1 = I2S, 2 = right-justified, 3 = TDM. In the left- and right-justified framings the left subframe runs while `fclk` is high. Subframe bit 31 is driven on the falling edge at which a new `fclk` level is first captured, followed by bits 30..0 on the next 31 edges. Any further bit clocks in the same half drive 0.
- R2: In I2S the left subframe runs while `fclk` is low, and every subframe bit appears one bit clock later than in left-justified framing. During the first bit clock of each half, `sdata` carries the final bit left over from the previous half, or 0 if no bit is left over.
- R3: In the left-justified, I2S and TDM framings, subframe bits 31..8 carry the audio word MSB-aligned. Bits 7..0 carry the channel's auxiliary byte when `ins_en` is 1 and are 0 when it is 0.
- R4: In right-justified framing, the audio word of N bits sits in subframe bits N-1..0 with its MSB at bit N-1. Bits 31..24 carry the auxiliary byte when `ins_en` is 1, and every other bit is 0.
- R5: With `bypass` low, the word length N equals `wlen` clamped to the range 16..24. The audio word is the upper N bits of the 24-bit sample, and the discarded low-order bits are sent as 0.
- R6: With `bypass` high, N is 24 whatever `wlen` is, so all sample bits pass unchanged (bits 23..0 in right-justified framing).
- R7: In TDM, a rising edge of `fclk` starts a frame. The left subframe fills bit positions 0..31 after it, the right subframe fills positions 32..63, and all later positions are 0.
- R8: Both samples, both auxiliary bytes, `wlen`, `bypass` and `ins_en` are used only at the start of the left subframe. Changing them later in the frame has no effect on the bits sent in that frame.
- R9: `len_err` rises for exactly one bit clock, one falling edge after a subframe boundary is captured, when `ins_en` is 1 at that edge and the boundary follows an earlier boundary after reset at a distance other than 32 bit clocks. In TDM the condition is instead a frame shorter than 64 bit clocks. With `ins_en` low, `len_err` never rises.
- R10: While `rst_n` is low, `sdata` and `len_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; the block acts on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fclk | input | 1 | Frame clock, or the sync pulse in TDM |
| fmt_sel | input | 2 | Framing select (0 LJ, 1 I2S, 2 RJ, 3 TDM) |
| wlen | input | 5 | Requested audio word length |
| bypass | input | 1 | Sends all 24 sample bits without shortening |
| ins_en | input | 1 | Enables auxiliary byte insertion and length checking |
| left_in | input | 24 | Left sample |
| right_in | input | 24 | Right sample |
| aux_left | input | 8 | Auxiliary byte for the left subframe |
| aux_right | input | 8 | Auxiliary byte for the right subframe |
| sdata | output | 1 | Serial data |
| len_err | output | 1 | Subframe-length error pulse |

## Verification
Two things can happen on the same falling edge. A frame-clock boundary that closes a short subframe also loads the next subframe into the shift path and raises the length flag. In I2S framing, the same edge both emits the last bit of the previous half and captures a fresh word. The bench provokes this with 24-bit halves and with 48-bit TDM frames while insertion is enabled. A behavioural model, built from bit queues, predicts both `sdata` and `len_err` for every bit clock. The bench also changes every data input two bit clocks into each half, so a frame that took up the new values shows up as a bit mismatch.

// File: rtl/aatx_pkg.sv
package aatx_pkg;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'd0,
      FMT_I2S = 2'd1,
      FMT_RJ  = 2'd2,
      FMT_TDM = 2'd3
   } fmt_e;

endpackage

// File: rtl/aatx_word_pack.sv
module aatx_word_pack
   import aatx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int AUX_W    = 8,
   parameter int WLEN_W   = 5,
   parameter int WL_MIN   = 16,
   localparam int SLOT_W  = SAMPLE_W + AUX_W
) (
   input  fmt_e                fmt,
   input  logic [WLEN_W-1:0]   wlen,
   input  logic                bypass,
   input  logic                ins_en,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [AUX_W-1:0]    aux,
   output logic [SLOT_W-1:0]   word
);

   localparam int SHW = $clog2(SAMPLE_W + 1);
   localparam logic [WLEN_W-1:0] WL_LO = WLEN_W'(WL_MIN);
   localparam logic [WLEN_W-1:0] WL_HI = WLEN_W'(SAMPLE_W);

   if (WL_MIN > SAMPLE_W) begin : g_bad_min
      $error("aatx_word_pack: WL_MIN exceeds SAMPLE_W");
   end
   if ((1 << WLEN_W) <= SAMPLE_W) begin : g_bad_wlen
      $error("aatx_word_pack: WLEN_W too narrow for SAMPLE_W");
   end

   logic [WLEN_W-1:0]   wl_clamp;
   logic [SHW-1:0]      eff_len;
   logic [SHW-1:0]      drop;
   logic [SAMPLE_W-1:0] kept;
   logic [AUX_W-1:0]    side;

   always_comb begin
      if (wlen < WL_LO)      wl_clamp = WL_LO;
      else if (wlen > WL_HI) wl_clamp = WL_HI;
      else                   wl_clamp = wlen;
      eff_len = bypass ? SHW'(SAMPLE_W) : SHW'(wl_clamp);
      drop    = SHW'(SAMPLE_W) - eff_len;
      kept    = sample & ({SAMPLE_W{1'b1}} << drop);
      side    = ins_en ? aux : '0;
      if (fmt == FMT_RJ) word = {side, kept >> drop};
      else               word = {kept, side};
   end

endmodule

// File: rtl/aatx_frame_track.sv
module aatx_frame_track
   import aatx_pkg::*;
#(
   parameter int SLOT_W = 32,
   parameter int CNT_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fclk,
   input  fmt_e             fmt,
   input  logic             ins_en,
   output logic             left_ld,
   output logic             right_ld,
   output logic             len_err,
   output logic [CNT_W-1:0] pos
);

   localparam logic [CNT_W-1:0] ONE_SLOT = CNT_W'(SLOT_W);
   localparam logic [CNT_W-1:0] TWO_SLOT = CNT_W'(2 * SLOT_W);
   localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

   if ((1 << CNT_W) - 1 <= 2 * SLOT_W) begin : g_bad_cnt
      $error("aatx_frame_track: CNT_W cannot span two subframes");
   end

   logic             fclk_q;
   logic             seen;
   logic [CNT_W-1:0] cnt;
   logic             err_q;
   logic             rise, fall, bound, bad_len;

   always_comb begin
      rise = fclk & ~fclk_q;
      fall = ~fclk & fclk_q;
      unique case (fmt)
         FMT_TDM: begin
            bound    = rise;
            left_ld  = rise;
            right_ld = seen && (cnt == ONE_SLOT) && !rise;
            bad_len  = cnt < TWO_SLOT;
         end
         FMT_I2S: begin
            bound    = rise | fall;
            left_ld  = fall;
            right_ld = rise;
            bad_len  = cnt != ONE_SLOT;
         end
         default: begin
            bound    = rise | fall;
            left_ld  = rise;
            right_ld = fall;
            bad_len  = cnt != ONE_SLOT;
         end
      endcase
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fclk_q <= 1'b0;
         seen   <= 1'b0;
         cnt    <= '0;
         err_q  <= 1'b0;
      end else begin
         fclk_q <= fclk;
         err_q  <= bound && seen && ins_en && bad_len;
         if (bound) begin
            cnt  <= CNT_W'(1);
            seen <= 1'b1;
         end else if (cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign len_err = err_q;
   assign pos     = cnt;

   // R9
   err_cause_chk: assert property (@(negedge clk) disable iff (!rst_n)
      len_err |-> $past(ins_en));

   // R9
   err_edge_chk: assert property (@(negedge clk) disable iff (!rst_n)
      len_err |-> $past(fclk != fclk_q));

endmodule

// File: rtl/aatx_shift_out.sv
module aatx_shift_out #(
   parameter int SLOT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              delay,
   input  logic [SLOT_W-1:0] word,
   output logic              sd
);

   if (SLOT_W < 2) begin : g_bad_slot
      $error("aatx_shift_out: SLOT_W too small");
   end

   logic [SLOT_W-1:0] sh;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
         sd <= 1'b0;
      end else if (load && delay) begin
         sd <= sh[SLOT_W-1];
         sh <= word;
      end else if (load) begin
         sd <= word[SLOT_W-1];
         sh <= {word[SLOT_W-2:0], 1'b0};
      end else begin
         sd <= sh[SLOT_W-1];
         sh <= {sh[SLOT_W-2:0], 1'b0};
      end
   end

   // R1
   lead_bit_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (load && !delay) |=> (sd == $past(word[SLOT_W-1])));

   // R2
   late_bit_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (load && delay) |=> (sd == $past(sh[SLOT_W-1])));

   // R1
   shift_bit_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !load |=> (sd == $past(sh[SLOT_W-1])));

endmodule

// File: rtl/aux_audio_tx.sv
module aux_audio_tx
   import aatx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int AUX_W    = 8,
   parameter int WLEN_W   = 5,
   parameter int WL_MIN   = 16,
   parameter int CNT_W    = 7
) (
   input  logic                bclk,
   input  logic                rst_n,
   input  logic                fclk,
   input  logic [1:0]          fmt_sel,
   input  logic [WLEN_W-1:0]   wlen,
   input  logic                bypass,
   input  logic                ins_en,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   input  logic [AUX_W-1:0]    aux_left,
   input  logic [AUX_W-1:0]    aux_right,
   output logic                sdata,
   output logic                len_err
);

   localparam int SLOT_W = SAMPLE_W + AUX_W;
   localparam int N_CH   = 2;

   if (SLOT_W != 32) begin : g_bad_slot
      $error("aux_audio_tx: subframe must total 32 bits");
   end

   fmt_e fmt;
   assign fmt = fmt_e'(fmt_sel);

   logic [SAMPLE_W-1:0] ch_smp [N_CH];
   logic [AUX_W-1:0]    ch_aux [N_CH];
   logic [SLOT_W-1:0]   ch_word[N_CH];

   assign ch_smp[0] = left_in;
   assign ch_smp[1] = right_in;
   assign ch_aux[0] = aux_left;
   assign ch_aux[1] = aux_right;

   for (genvar c = 0; c < N_CH; c++) begin : g_pack
      aatx_word_pack #(
         .SAMPLE_W(SAMPLE_W),
         .AUX_W   (AUX_W),
         .WLEN_W  (WLEN_W),
         .WL_MIN  (WL_MIN)
      ) i_pack (
         .fmt   (fmt),
         .wlen  (wlen),
         .bypass(bypass),
         .ins_en(ins_en),
         .sample(ch_smp[c]),
         .aux   (ch_aux[c]),
         .word  (ch_word[c])
      );
   end

   logic             left_ld, right_ld;
   logic [CNT_W-1:0] pos;

   aatx_frame_track #(
      .SLOT_W(SLOT_W),
      .CNT_W (CNT_W)
   ) i_track (
      .clk     (bclk),
      .rst_n   (rst_n),
      .fclk    (fclk),
      .fmt     (fmt),
      .ins_en  (ins_en),
      .left_ld (left_ld),
      .right_ld(right_ld),
      .len_err (len_err),
      .pos     (pos)
   );

   logic [SLOT_W-1:0] right_hold;
   logic [SLOT_W-1:0] next_word;

   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n)       right_hold <= '0;
      else if (left_ld) right_hold <= ch_word[1];
   end

   assign next_word = left_ld ? ch_word[0] : right_hold;

   aatx_shift_out #(
      .SLOT_W(SLOT_W)
   ) i_shift (
      .clk  (bclk),
      .rst_n(rst_n),
      .load (left_ld | right_ld),
      .delay(fmt == FMT_I2S),
      .word (next_word),
      .sd   (sdata)
   );

   // R7
   tdm_quiet_chk: assert property (@(negedge bclk) disable iff (!rst_n)
      (fmt == FMT_TDM && $past(fmt) == FMT_TDM && pos > CNT_W'(2 * SLOT_W)) |-> !sdata);

endmodule

// File: tb/test_aux_audio_tx.sv
module test_aux_audio_tx;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fclk = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic [4:0]  wlen = 5'd24;
   logic        bypass = 1'b0;
   logic        ins_en = 1'b0;
   logic [23:0] left_in = '0;
   logic [23:0] right_in = '0;
   logic [7:0]  aux_left = '0;
   logic [7:0]  aux_right = '0;
   logic        sdata;
   logic        len_err;

   aux_audio_tx i_aux_audio_tx (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .fclk     (fclk),
      .fmt_sel  (fmt_sel),
      .wlen     (wlen),
      .bypass   (bypass),
      .ins_en   (ins_en),
      .left_in  (left_in),
      .right_in (right_in),
      .aux_left (aux_left),
      .aux_right(aux_right),
      .sdata    (sdata),
      .len_err  (len_err)
   );

   always #2.5ns bclk = ~bclk;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R10";

   // reference model state
   bit          q[$];
   logic        m_prev = 1'b0;
   logic        m_seen = 1'b0;
   int          m_cnt = 0;
   logic [31:0] m_right = '0;
   logic        pend = 1'b0;
   logic        pend_b = 1'b0;
   logic        pend_e = 1'b0;
   logic        rel = 1'b0;

   task automatic chk(input logic got, input logic exp, input string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   function automatic bit popz();
      if (q.size() == 0) return 1'b0;
      return q.pop_front();
   endfunction

   function automatic void load_q(input logic [31:0] w);
      q.delete();
      for (int i = 31; i >= 0; i--) q.push_back(w[i]);
   endfunction

   // subframe layout from R3..R6
   function automatic logic [31:0] mdl_word(input logic [1:0] f, input logic [23:0] s,
                                            input logic [7:0] a, input logic [4:0] wl,
                                            input logic byp, input logic ins);
      int n;
      logic [31:0] w;
      w = '0;
      if (byp) n = 24;
      else if (wl < 16) n = 16;
      else if (wl > 24) n = 24;
      else n = int'(wl);
      if (f == 2'd2) begin
         for (int i = 0; i < n; i++) w[n-1-i] = s[23-i];
         if (ins) for (int i = 0; i < 8; i++) w[24+i] = a[i];
      end else begin
         for (int i = 0; i < n; i++) w[31-i] = s[23-i];
         if (ins) w[7:0] = a;
      end
      return w;
   endfunction

   task automatic slot(input logic lv);
      logic rise, fall, tdm, bnd, ld_l, ld_r, errx, b;
      logic [31:0] w;
      @(posedge bclk);
      #1ns;
      if (pend) begin
         chk(sdata, pend_b, "sdata");
         chk(len_err, pend_e, "len_err");
      end
      if (rel) begin
         rst_n = 1'b1;
         rel = 1'b0;
      end
      fclk = lv;
      tdm  = (fmt_sel == 2'd3);
      rise = lv && !m_prev;
      fall = !lv && m_prev;
      bnd  = tdm ? rise : (rise || fall);
      ld_l = tdm ? rise : ((fmt_sel == 2'd1) ? fall : rise);
      ld_r = tdm ? (m_seen && m_cnt == 32 && !rise) : ((fmt_sel == 2'd1) ? rise : fall);
      errx = bnd && m_seen && ins_en && (tdm ? (m_cnt < 64) : (m_cnt != 32));
      if (ld_l) begin
         w = mdl_word(fmt_sel, left_in, aux_left, wlen, bypass, ins_en);
         m_right = mdl_word(fmt_sel, right_in, aux_right, wlen, bypass, ins_en);
      end else begin
         w = m_right;
      end
      if (ld_l || ld_r) begin
         if (fmt_sel == 2'd1) begin
            b = popz();
            load_q(w);
         end else begin
            load_q(w);
            b = popz();
         end
      end else begin
         b = popz();
      end
      if (bnd) begin
         m_cnt = 1;
         m_seen = 1'b1;
      end else if (m_cnt < 127) begin
         m_cnt++;
      end
      m_prev = lv;
      pend   = 1'b1;
      pend_b = b;
      pend_e = errx;
   endtask

   // R8: data, aux, word length and bypass change mid-frame
   task automatic scramble();
      left_in   = 24'($urandom);
      right_in  = 24'($urandom);
      aux_left  = 8'($urandom);
      aux_right = 8'($urandom);
      wlen      = 5'($urandom);
      bypass    = 1'($urandom);
   endtask

   task automatic new_data();
      left_in   = 24'($urandom);
      right_in  = 24'($urandom);
      aux_left  = 8'($urandom);
      aux_right = 8'($urandom);
   endtask

   task automatic set_ctl(input logic [1:0] f, input logic [4:0] wl, input logic byp,
                          input logic ins);
      fmt_sel = f;
      wlen    = wl;
      bypass  = byp;
      ins_en  = ins;
   endtask

   task automatic half(input logic lv, input int h);
      for (int p = 0; p < h; p++) begin
         slot(lv);
         if (p == 1) scramble();
      end
   endtask

   task automatic tdm_frame(input int f);
      slot(1'b1);
      for (int p = 1; p < f; p++) begin
         slot(1'b0);
         if (p == 2) scramble();
      end
   endtask

   task automatic do_reset();
      @(posedge bclk);
      #1ns;
      if (pend) begin
         chk(sdata, pend_b, "sdata");
         chk(len_err, pend_e, "len_err");
      end
      pend = 1'b0;
      rst_n = 1'b0;
      fclk = 1'b0;
      q.delete();
      m_prev = 1'b0;
      m_seen = 1'b0;
      m_cnt = 0;
      m_right = '0;
      @(negedge bclk);
      #1ns;
      cur_req = "R10";
      chk(sdata, 1'b0, "sdata in reset");
      chk(len_err, 1'b0, "len_err in reset");
      repeat (2) @(posedge bclk);
      rel = 1'b1;
   endtask

   // left-justified or right-justified frames, left half high
   task automatic just_frames(input logic [1:0] f, input logic [4:0] wl, input logic byp,
                              input logic ins, input int h, input int n);
      for (int k = 0; k < n; k++) begin
         set_ctl(f, wl, byp, ins);
         new_data();
         half(1'b1, h);
         half(1'b0, h);
      end
   endtask

   task automatic i2s_frames(input logic [4:0] wl, input logic byp, input logic ins,
                             input int n);
      for (int k = 0; k < n; k++) begin
         set_ctl(2'd1, wl, byp, ins);
         new_data();
         half(1'b0, 32);
         half(1'b1, 32);
      end
   endtask

   initial begin : watchdog
      #900us;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      // R10: reset state
      do_reset();

      // R1, R3: left-justified with insertion, full words
      cur_req = "R3";
      just_frames(2'd0, 5'd24, 1'b0, 1'b1, 32, 3);

      // R5: shortened words in left-justified framing
      do_reset();
      cur_req = "R5";
      just_frames(2'd0, 5'd18, 1'b0, 1'b1, 32, 2);

      // R6: bypass ignores the 16-bit word length
      cur_req = "R6";
      just_frames(2'd0, 5'd16, 1'b1, 1'b1, 32, 2);

      // R3: insertion off leaves the low byte zero
      do_reset();
      cur_req = "R3";
      just_frames(2'd0, 5'd20, 1'b0, 1'b0, 32, 2);

      // R2, R8: I2S with one-bit delay, inputs scrambled mid-frame
      do_reset();
      cur_req = "R2";
      set_ctl(2'd1, 5'd24, 1'b0, 1'b1);
      half(1'b1, 32);
      i2s_frames(5'd24, 1'b0, 1'b1, 3);
      cur_req = "R8";
      i2s_frames(5'd17, 1'b0, 1'b0, 2);

      // R4, R5, R6: right-justified layouts
      do_reset();
      cur_req = "R4";
      just_frames(2'd2, 5'd20, 1'b0, 1'b1, 32, 2);
      just_frames(2'd2, 5'd16, 1'b0, 1'b1, 32, 1);
      cur_req = "R5";
      just_frames(2'd2, 5'd31, 1'b0, 1'b1, 32, 1);
      just_frames(2'd2, 5'd3, 1'b0, 1'b0, 32, 1);
      cur_req = "R6";
      just_frames(2'd2, 5'd16, 1'b1, 1'b1, 32, 2);

      // R9: short subframes with insertion flag an error
      do_reset();
      cur_req = "R9";
      just_frames(2'd0, 5'd24, 1'b0, 1'b1, 24, 2);
      // R1: long halves send zeros after bit 0, R9: no flag with insertion off
      cur_req = "R1";
      just_frames(2'd0, 5'd24, 1'b0, 1'b0, 40, 2);
      cur_req = "R9";
      just_frames(2'd0, 5'd24, 1'b0, 1'b1, 32, 2);

      // R7: TDM slots
      do_reset();
      cur_req = "R7";
      set_ctl(2'd3, 5'd24, 1'b0, 1'b1);
      for (int k = 0; k < 2; k++) begin
         set_ctl(2'd3, 5'd24, 1'b0, 1'b1);
         new_data();
         tdm_frame(128);
      end
      set_ctl(2'd3, 5'd22, 1'b0, 1'b1);
      new_data();
      tdm_frame(64);
      // R9: a 48-bit TDM frame is flagged at the next sync
      cur_req = "R9";
      set_ctl(2'd3, 5'd24, 1'b0, 1'b1);
      new_data();
      tdm_frame(48);
      set_ctl(2'd3, 5'd24, 1'b0, 1'b1);
      new_data();
      tdm_frame(64);
      set_ctl(2'd3, 5'd24, 1'b0, 1'b0);
      new_data();
      tdm_frame(40);
      set_ctl(2'd3, 5'd24, 1'b0, 1'b0);
      new_data();
      tdm_frame(64);

      do_reset();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule